// File: doc/BRIEF.md
# Noise-Shaped Phase Sine Synthesizer

This block is the digital core of a direct digital frequency synthesizer. On every enabled clock a 16-bit phase accumulator adds the frequency word and wraps modulo 2^16. The upper 12 bits of the phase are not cut down to the table address width directly. A fourth-order error-feedback delta-sigma requantizer shapes them down to an 8-bit address. Each discarded 4-bit remainder is fed back through the binomial weights of (1 - z^-1)^4. This moves the phase-truncation error to high frequencies and keeps the average of the address equal to the full-precision phase.

The 8-bit shaped phase addresses a 256-entry sine table that is computed at elaboration. The table returns signed 12-bit samples, ready to drive a downstream converter. Every stage has a register, so the core delivers one sample per clock. The sample-enable input acts as a clock enable for the whole pipeline. A valid flag marks each clock that carries a fresh sample.

Top module: `dds_ns_core`

## Requirements
- R1: On each clock with `smp_en` high, the internal phase adds `freq_word` modulo 65536. Its upper 12 bits (bits 15..4) form the shaper input x.
- R2: On each enabled clock the shaper forms v = x + 4*d1 - 6*d2 + 4*d3 - d4 (mod 4096). Here d1..d4 are the four most recent discarded remainders, newest first. It stores the address y = v[11:4] and the new remainder v[3:0].
- R3: Each stored address y, taken as y*16, lies within 120 of the x it was formed from, measured modulo 4096.
- R4: Table entry k (k = 0..255) holds round(2047*sin(2*pi*k/256)) as a 12-bit two's-complement value. Entry 64 is +2047 and entry 192 is -2047.
- R5: `amp` is the table entry for the address stored at the previous enabled clock. It is registered on an enabled clock. `amp_vld` goes high in the clock after an enabled edge only when an earlier enabled edge has occurred since reset; otherwise it is low.
- R6: While `smp_en` is low, `amp` and all internal state hold and `amp_vld` is low.
- R7: A synchronous active-high `rst` clears the phase, the remainder history, the address, `amp` (to 0) and `amp_vld`.
- R8: With `freq_word` zero and x constant, the mean of `amp` over 256 samples follows the full-resolution phase x/4096 of a turn. For x = 5 it is about 15.7, where plain truncation would give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable; advances the whole pipeline |
| freq_word | input | 16 | Phase increment per sample |
| amp | output | 12 | Signed sine amplitude sample |
| amp_vld | output | 1 | High when `amp` holds a fresh sample |

## Verification
On every clock the assertions check that the state holds while the enable is low, that reset clears the phase, and that the shaped address stays within the error bound of its input phase. They also check that amplitudes stay inside the table range and that the valid flag only follows an enabled edge. The exact sample values are shown only by the bench's per-cycle reference model. That model covers accumulator wrap, negative-going phase, irregular enable patterns and the four-deep remainder history. Only the bench's long zero-frequency run can show the averaging property: that the shaped phase recovers the sub-address phase in the mean.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int DDS_PHASE_W = 16;
    localparam int DDS_TRUNC_W = 12;
    localparam int DDS_ADDR_W  = 8;
    localparam int DDS_AMP_W   = 12;
    localparam int DDS_ORDER   = 4;
    localparam real DDS_PI     = 3.14159265358979323846;

    // Stage record between the shaper and the table
    typedef struct packed {
        logic                  live;
        logic [DDS_ADDR_W-1:0] addr;
    } shaped_t;

    // Weight of the k-th delayed remainder in the feedback: -(-1)^k * C(order,k)
    function automatic int ntf_coef(input int order, input int k);
        int c;
        c = 1;
        for (int i = 0; i < k; i++) c = c * (order - i) / (i + 1);
        return (k % 2 == 1) ? c : -c;
    endfunction

    // Rounded sine sample for table index k
    function automatic int sine_entry(input int k, input int addr_w, input int amp_w);
        real a;
        a = real'((1 << (amp_w - 1)) - 1) * $sin(2.0 * DDS_PI * real'(k) / real'(1 << addr_w));
        return int'(a);
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = dds_pkg::DDS_PHASE_W,
    parameter int TRUNC_W = dds_pkg::DDS_TRUNC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] step,
    output logic [TRUNC_W-1:0] phase_hi
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= acc_q + step;
    end

    assign phase_hi = acc_q[PHASE_W-1 -: TRUNC_W];

    p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));
    p_acc_reset_r7: assert property (@(posedge clk)
        rst |=> (acc_q == '0));
endmodule

// File: rtl/dds_ns_shaper.sv
module dds_ns_shaper
    import dds_pkg::*;
#(
    parameter int TRUNC_W = DDS_TRUNC_W,
    parameter int ADDR_W  = DDS_ADDR_W,
    parameter int ORDER   = DDS_ORDER
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [TRUNC_W-1:0] x_i,
    output shaped_t            q_o
);
    localparam int DROP_W = TRUNC_W - ADDR_W;
    localparam int BOUND  = ((1 << DROP_W) - 1) * (1 << (ORDER - 1));

    logic [DROP_W-1:0]  hist_q [ORDER];
    logic [TRUNC_W-1:0] sum;
    shaped_t            out_q;

    always_comb begin
        int s;
        s = int'(x_i);
        for (int k = 0; k < ORDER; k++)
            s = s + ntf_coef(ORDER, k + 1) * int'(hist_q[k]);
        sum = TRUNC_W'(s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ORDER; k++) hist_q[k] <= '0;
            out_q <= '0;
        end else if (en) begin
            hist_q[0] <= sum[DROP_W-1:0];
            for (int k = 1; k < ORDER; k++) hist_q[k] <= hist_q[k-1];
            out_q.addr <= sum[TRUNC_W-1:DROP_W];
            out_q.live <= 1'b1;
        end
    end

    assign q_o = out_q;

    p_shape_bound_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> (($signed(TRUNC_W'({out_q.addr, {DROP_W{1'b0}}} - $past(x_i))) <= BOUND) &&
                ($signed(TRUNC_W'({out_q.addr, {DROP_W{1'b0}}} - $past(x_i))) >= -BOUND)));
    p_shape_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W = DDS_ADDR_W,
    parameter int AMP_W  = DDS_AMP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  shaped_t                 s_i,
    output logic signed [AMP_W-1:0] amp_o,
    output logic                    vld_o
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

    logic signed [AMP_W-1:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        assign rom[k] = AMP_W'(sine_entry(k, ADDR_W, AMP_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= en & s_i.live;
            if (en) amp_o <= rom[s_i.addr];
        end
    end

    p_amp_range_r4: assert property (@(posedge clk) disable iff (rst)
        (amp_o <= AMP_W'(AMP_MAX)) && (amp_o >= -AMP_W'(AMP_MAX)));
    p_amp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(amp_o) && !vld_o));
    p_vld_src_r5: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(en));
endmodule

// File: rtl/dds_ns_core.sv
module dds_ns_core
    import dds_pkg::*;
#(
    parameter int PHASE_W = DDS_PHASE_W,
    parameter int TRUNC_W = DDS_TRUNC_W,
    parameter int ADDR_W  = DDS_ADDR_W,
    parameter int AMP_W   = DDS_AMP_W,
    parameter int ORDER   = DDS_ORDER
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic [PHASE_W-1:0]      freq_word,
    output logic signed [AMP_W-1:0] amp,
    output logic                    amp_vld
);
    logic [TRUNC_W-1:0] phase_hi;
    shaped_t            shaped;

    dds_phase_acc #(.PHASE_W(PHASE_W), .TRUNC_W(TRUNC_W)) u_acc (
        .clk(clk), .rst(rst), .en(smp_en), .step(freq_word), .phase_hi(phase_hi)
    );

    dds_ns_shaper #(.TRUNC_W(TRUNC_W), .ADDR_W(ADDR_W), .ORDER(ORDER)) u_shape (
        .clk(clk), .rst(rst), .en(smp_en), .x_i(phase_hi), .q_o(shaped)
    );

    dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk(clk), .rst(rst), .en(smp_en), .s_i(shaped), .amp_o(amp), .vld_o(amp_vld)
    );

    p_reset_out_r7: assert property (@(posedge clk)
        rst |=> (amp == '0 && !amp_vld));
endmodule

// File: tb/dds_ns_core_test.sv
`timescale 1ns/1ps
module dds_ns_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] fcw = '0;
    logic signed [11:0] amp;
    logic        vld;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    dds_ns_core uut (.clk(clk), .rst(rst), .smp_en(en), .freq_word(fcw),
                     .amp(amp), .amp_vld(vld));

    // reference model state
    int tab [256];
    int m_acc, m_y, m_amp, m_d1, m_d2, m_d3, m_d4;
    bit m_live, m_vld;

    initial begin
        for (int k = 0; k < 256; k++)
            tab[k] = $rtoi($floor(2047.0 * $sin(6.283185307179586 * k / 256.0) + 0.5));
    end

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_y = 0; m_amp = 0; m_live = 0; m_vld = 0;
            m_d1 = 0; m_d2 = 0; m_d3 = 0; m_d4 = 0;
        end else if (en) begin
            int x, v;
            m_amp = tab[m_y];
            m_vld = m_live;
            x = (m_acc >> 4) & 4095;
            v = x + 4*m_d1 - 6*m_d2 + 4*m_d3 - m_d4;
            m_d4 = m_d3; m_d3 = m_d2; m_d2 = m_d1; m_d1 = v & 15;
            m_y = (v >>> 4) & 255;
            m_live = 1;
            m_acc = (m_acc + int'(fcw)) & 65535;
        end else begin
            m_vld = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R1 R2 R4 R5)
    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(amp) == m_amp, "R1 R2 R4 amp", int'(amp), m_amp);
            check(vld == m_vld, "R5 valid", int'(vld), int'(m_vld));
        end
    end

    task automatic run(input int n, input logic [15:0] f, input int en_mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fcw = f;
            en = (en_mode == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int mx, mn, held;
        real acc_sum, mean;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(amp == 0, "R7 amp after reset", int'(amp), 0);
        check(vld == 0, "R7 valid after reset", int'(vld), 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R5: first enabled edge gives no valid, second does
        @(negedge clk); en = 1'b1; fcw = 16'h0100;
        @(negedge clk); check(vld == 0, "R5 first edge", int'(vld), 0);
        @(negedge clk); check(vld == 1, "R5 second edge", int'(vld), 1);

        // R4: aligned steps address exact table entries
        do_reset();
        mx = -5000; mn = 5000;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (int'(amp) > mx) mx = int'(amp);
            if (int'(amp) < mn) mn = int'(amp);
            fcw = 16'h1000; en = 1'b1;
        end
        check(mx == 2047, "R4 peak", mx, 2047);
        check(mn == -2047, "R4 trough", mn, -2047);

        // R1 R2: wrap, odd steps, irregular enable, negative step
        run(1500, 16'h1234, 1);
        run(800, 16'hFFFF, 1);
        run(600, 16'h8001, 0);
        run(400, 16'h0007, 1);

        // R6: hold while disabled
        @(negedge clk); en = 1'b0;
        @(negedge clk); held = int'(amp);
        repeat (5) @(negedge clk);
        check(int'(amp) == held, "R6 amp hold", int'(amp), held);
        check(vld == 0, "R6 valid low", int'(vld), 0);

        // R7: reset mid-run clears output
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(amp == 0, "R7 amp cleared", int'(amp), 0);
        rst = 1'b0;

        // R8 R3: constant sub-address phase x = 5
        @(negedge clk); fcw = 16'h0050; en = 1'b1;
        @(negedge clk); fcw = 16'h0000;
        acc_sum = 0.0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (i >= 20 && i < 276) acc_sum += real'(amp);
            check(int'(amp) <= 400 && int'(amp) >= -400, "R3 amp near phase", int'(amp), 16);
        end
        mean = acc_sum / 256.0;
        check(mean > 12.7 && mean < 18.7, "R8 mean amp", $rtoi(mean), 16);

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule